// File: doc/BRIEF.md
# Switch Interrupt and Overtemperature Alert Logic

This block turns debounced switch states and digital thermal comparator flags into two active-low alert lines for a host controller, plus a readable overtemperature status bit and the output enables for two pass-through switch outputs. A switch that changes state raises the interrupt line, unless its mask bit is set. The host clears both alert lines by pulling chip-select low to start a serial access. The overtemperature status bit is hysteretic and keeps the real thermal state, so the host can still read it after the alert line has been cleared.

Switches 0 and 1 can be taken over as direct inputs. In that mode they are hidden from the switch status vector and cannot interrupt. Their pass-through outputs are then driven, but only while scan mode is off. Thermal detection only runs while the global wetting enable is set and at least one input is not open. The open-drain outputs are modelled as logic levels where low means asserted.

Top module: `sw_alert_top`

## Requirements
- R1: A change of state on switch input i whose mask bit `irq_mask_i[i]` is 0 drives `irq_no` low after the next rising clock edge. `irq_no` then stays low until it is cleared.
- R2: A falling edge on `cs_ni`, detected at a clock edge, drives `irq_no` high after that edge. A change on an input whose mask bit is 1 never drives `irq_no` low.
- R3: `sw_stat_o` shows the switch states one clock edge after they are applied. While `direct_mode_i` is 1, bits 0 and 1 of `sw_stat_o` read 0, and changes on inputs 0 and 1 never drive `irq_no` low.
- R4: While thermal detection is active, a rising edge of `temp_hi_i` drives `ot_alert_no` low after the next clock edge.
- R5: A falling edge on `cs_ni` drives `ot_alert_no` high even if `temp_hi_i` is still 1. The alert asserts again only on a fresh rising edge of `temp_hi_i`.
- R6: `ot_status_o` goes to 1 one edge after `temp_hi_i` is seen at 1. It goes back to 0 only after `temp_lo_i` is seen at 1 while `temp_hi_i` is 0. Chip-select does not affect it.
- R7: While `wet_en_i` is 0 or `all_open_i` is 1, thermal detection is inactive: `ot_alert_no` is 1, `ot_status_o` is 0, and `temp_hi_i` is ignored. If detection becomes active again while `temp_hi_i` is 1, that counts as a fresh rising edge.
- R8: `dout_oe_o` is 2'b11, and `dout_o` follows switch inputs 1:0, only while `direct_mode_i` is 1 and `scan_mode_i` is 0. Otherwise `dout_oe_o` is 2'b00. This path is combinational.
- R9: A switch change in the same cycle as a chip-select falling edge is not lost: `irq_no` is low after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sw_state_i | input | 8 | Debounced switch states |
| irq_mask_i | input | 8 | Per-input interrupt mask, 1 = masked |
| direct_mode_i | input | 1 | Inputs 0 and 1 used as direct pass-through |
| scan_mode_i | input | 1 | Scan (polling) mode active |
| wet_en_i | input | 1 | Global wetting enable |
| all_open_i | input | 1 | All switch inputs open |
| temp_hi_i | input | 1 | Temperature above warning threshold |
| temp_lo_i | input | 1 | Temperature below hysteresis threshold |
| cs_ni | input | 1 | Serial chip-select, active low |
| irq_no | output | 1 | Interrupt, active low |
| ot_alert_no | output | 1 | Overtemperature alert, active low |
| ot_status_o | output | 1 | Hysteretic overtemperature status |
| sw_stat_o | output | 8 | Switch status vector |
| dout_o | output | 2 | Pass-through values of inputs 1:0 |
| dout_oe_o | output | 2 | Pass-through output enables |

## Verification
Every registered result (`irq_no`, `ot_alert_no`, `ot_status_o`, `sw_stat_o`) is due exactly one rising edge after the stimulus that causes it. Chip-select edges are also detected at that same edge, because the previous chip-select level is held in a register. The bench changes inputs on the falling clock edge and samples registered outputs on the following falling edge, half a period after the edge that updates them. The pass-through enables are combinational, so they are sampled one nanosecond after their inputs change.

// File: rtl/sw_alert_pkg.sv
package sw_alert_pkg;
  localparam int unsigned N_SW_DEF  = 8;
  localparam int unsigned N_DIR_DEF = 2;

  typedef struct packed {
    logic hi;  // above warning threshold
    logic lo;  // below hysteresis threshold
  } therm_flags_t;
endpackage

// File: rtl/sw_irq_unit.sv
module sw_irq_unit #(
  parameter int unsigned N_SW  = 8,
  parameter int unsigned N_DIR = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_SW-1:0] sw_state_i,
  input  logic [N_SW-1:0] irq_mask_i,
  input  logic            direct_mode_i,
  input  logic            cs_fall_i,
  output logic            irq_o,
  output logic [N_SW-1:0] sw_stat_o
);
  localparam logic [N_SW-1:0] DIR_BITS = {{(N_SW-N_DIR){1'b0}}, {N_DIR{1'b1}}};

  logic [N_SW-1:0] sw_prev_q;
  logic [N_SW-1:0] elig;
  logic [N_SW-1:0] chg_vec;
  logic            primed_q;
  logic            irq_q;
  logic            chg_any;

  for (genvar i = 0; i < N_SW; i++) begin : g_elig
    if (i < N_DIR) begin : g_dir
      assign elig[i] = ~direct_mode_i;
    end else begin : g_norm
      assign elig[i] = 1'b1;
    end
  end

  // primed_q suppresses a false change on the first edge after reset
  assign chg_vec = (sw_state_i ^ sw_prev_q) & ~irq_mask_i & elig & {N_SW{primed_q}};
  assign chg_any = |chg_vec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_prev_q <= '0;
      primed_q  <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      sw_prev_q <= sw_state_i;
      primed_q  <= 1'b1;
      // a change coincident with the clear still wins (R9)
      irq_q     <= (irq_q & ~cs_fall_i) | chg_any;
    end
  end

  assign irq_o     = irq_q;
  assign sw_stat_o = sw_prev_q & elig;

  a_r1_change_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_any |=> irq_q);

  a_r1_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !cs_fall_i) |=> irq_q);

  a_r2_cs_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_fall_i && !chg_any) |=> !irq_q);

  a_r3_direct_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (direct_mode_i && !irq_q &&
     (((sw_state_i ^ sw_prev_q) & ~irq_mask_i & ~DIR_BITS) == '0)) |=> !irq_q);
endmodule

// File: rtl/ot_alert_unit.sv
module ot_alert_unit
  import sw_alert_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  therm_flags_t flags_i,
  input  logic         wet_en_i,
  input  logic         all_open_i,
  input  logic         cs_fall_i,
  output logic         alert_o,
  output logic         status_o
);
  logic act;
  logic hi_seen_q;
  logic rise;
  logic alert_q;
  logic status_q;

  assign act  = wet_en_i & ~all_open_i;
  assign rise = act & flags_i.hi & ~hi_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_seen_q <= 1'b0;
      alert_q   <= 1'b0;
      status_q  <= 1'b0;
    end else begin
      hi_seen_q <= act & flags_i.hi;
      if (!act) begin
        alert_q  <= 1'b0;
        status_q <= 1'b0;
      end else begin
        alert_q <= rise | (alert_q & ~cs_fall_i);
        if (flags_i.hi)      status_q <= 1'b1;
        else if (flags_i.lo) status_q <= 1'b0;
      end
    end
  end

  assign alert_o  = alert_q;
  assign status_o = status_q;

  a_r4_rise_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alert_q) |-> ($past(flags_i.hi) && !$past(hi_seen_q)));

  a_r5_cs_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_fall_i && !rise) |=> !alert_q);

  a_r6_status_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act && !flags_i.hi && !flags_i.lo) |=> $stable(status_q));

  a_r7_inactive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act |=> (!alert_q && !status_q));
endmodule

// File: rtl/passthru_en.sv
module passthru_en #(
  parameter int unsigned N_DIR = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_DIR-1:0] sw_i,
  input  logic             direct_mode_i,
  input  logic             scan_mode_i,
  output logic [N_DIR-1:0] dout_o,
  output logic [N_DIR-1:0] dout_oe_o
);
  logic drive;
  assign drive = direct_mode_i & ~scan_mode_i;

  for (genvar i = 0; i < N_DIR; i++) begin : g_pt
    assign dout_o[i]    = sw_i[i];
    assign dout_oe_o[i] = drive;
  end

  a_r8_scan_tristate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scan_mode_i || !direct_mode_i) |-> (dout_oe_o == '0));

  a_r8_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dout_oe_o != '0) |-> (dout_o == sw_i));
endmodule

// File: rtl/sw_alert_top.sv
module sw_alert_top
  import sw_alert_pkg::*;
#(
  parameter int unsigned N_SW  = N_SW_DEF,
  parameter int unsigned N_DIR = N_DIR_DEF
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_SW-1:0] sw_state_i,
  input  logic [N_SW-1:0] irq_mask_i,
  input  logic            direct_mode_i,
  input  logic            scan_mode_i,
  input  logic            wet_en_i,
  input  logic            all_open_i,
  input  logic            temp_hi_i,
  input  logic            temp_lo_i,
  input  logic            cs_ni,
  output logic            irq_no,
  output logic            ot_alert_no,
  output logic            ot_status_o,
  output logic [N_SW-1:0] sw_stat_o,
  output logic [N_DIR-1:0] dout_o,
  output logic [N_DIR-1:0] dout_oe_o
);
  logic         cs_prev_q;
  logic         cs_fall;
  logic         irq;
  logic         alert;
  therm_flags_t flags;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cs_prev_q <= 1'b1;
    else         cs_prev_q <= cs_ni;
  end
  assign cs_fall = cs_prev_q & ~cs_ni;

  assign flags.hi = temp_hi_i;
  assign flags.lo = temp_lo_i;

  sw_irq_unit #(.N_SW(N_SW), .N_DIR(N_DIR)) i_irq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .sw_state_i    (sw_state_i),
    .irq_mask_i    (irq_mask_i),
    .direct_mode_i (direct_mode_i),
    .cs_fall_i     (cs_fall),
    .irq_o         (irq),
    .sw_stat_o     (sw_stat_o)
  );

  ot_alert_unit i_ot (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flags_i    (flags),
    .wet_en_i   (wet_en_i),
    .all_open_i (all_open_i),
    .cs_fall_i  (cs_fall),
    .alert_o    (alert),
    .status_o   (ot_status_o)
  );

  passthru_en #(.N_DIR(N_DIR)) i_pt (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .sw_i          (sw_state_i[N_DIR-1:0]),
    .direct_mode_i (direct_mode_i),
    .scan_mode_i   (scan_mode_i),
    .dout_o        (dout_o),
    .dout_oe_o     (dout_oe_o)
  );

  assign irq_no      = ~irq;
  assign ot_alert_no = ~alert;
endmodule

// File: tb/test_sw_alert_top.sv
module test_sw_alert_top;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] sw = '0, mask = '0;
  logic       direct = 0, scan = 0, wet_en = 0, all_open = 0;
  logic       hi = 0, lo = 0, cs_n = 1;
  logic       irq_no, ot_alert_no, ot_status;
  logic [7:0] sw_stat;
  logic [1:0] dout, dout_oe;
  int         n_run = 0, n_fail = 0;
  bit         done = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  sw_alert_top i_sw_alert_top (
    .clk_i(clk), .rst_ni(rst_ni), .sw_state_i(sw), .irq_mask_i(mask),
    .direct_mode_i(direct), .scan_mode_i(scan), .wet_en_i(wet_en),
    .all_open_i(all_open), .temp_hi_i(hi), .temp_lo_i(lo), .cs_ni(cs_n),
    .irq_no(irq_no), .ot_alert_no(ot_alert_no), .ot_status_o(ot_status),
    .sw_stat_o(sw_stat), .dout_o(dout), .dout_oe_o(dout_oe)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cs_pulse();
    cs_n = 0; step(); cs_n = 1; step();
  endtask

  task automatic t_reset();
    chk("R1 reset irq", irq_no, 1);
    chk("R4 reset alert", ot_alert_no, 1);
    chk("R6 reset status", ot_status, 0);
    chk("R8 reset oe", dout_oe, 0);
    rst_ni = 1; step();
    chk("R1 no irq after reset", irq_no, 1);
  endtask

  task automatic t_irq_basic();
    sw[5] = 1; step();
    chk("R1 change sets irq", irq_no, 0);
    step();
    chk("R1 irq holds", irq_no, 0);
    chk("R3 status shows input", sw_stat, 8'h20);
    cs_n = 0; step();
    chk("R2 cs fall clears irq", irq_no, 1);
    cs_n = 1; step();
  endtask

  task automatic t_masked();
    mask = 8'h80; sw[7] = 1; step(); step();
    chk("R2 masked change ignored", irq_no, 1);
    mask = '0; step();
  endtask

  task automatic t_same_cycle();
    cs_n = 0; sw[3] = 1; step();
    chk("R9 change with cs fall kept", irq_no, 0);
    cs_n = 1; step();
    cs_pulse();
    chk("R9 later clear", irq_no, 1);
  endtask

  task automatic t_direct();
    direct = 1; step();
    sw[0] = 1; step(); step();
    chk("R3 direct input no irq", irq_no, 1);
    chk("R3 direct bits hidden", sw_stat, 8'hA8);
    chk("R8 oe driven", dout_oe, 2'b11);
    chk("R8 dout follows", dout, 2'b01);
    sw[1] = 1; #1;
    chk("R8 dout follows bit1", dout, 2'b11);
    scan = 1; #1;
    chk("R8 scan tristates", dout_oe, 2'b00);
    scan = 0; direct = 0; #1;
    chk("R8 normal mode tristates", dout_oe, 2'b00);
    @(negedge clk); step();
    chk("R3 bits visible out of direct", sw_stat, 8'hAB);
    cs_pulse();
  endtask

  task automatic t_therm();
    wet_en = 1; step();
    hi = 1; step();
    chk("R4 rise asserts alert", ot_alert_no, 0);
    chk("R6 status set", ot_status, 1);
    cs_n = 0; step();
    chk("R5 cs clears alert while hot", ot_alert_no, 1);
    chk("R6 status kept after cs", ot_status, 1);
    cs_n = 1; step(); step();
    chk("R5 held flag no reassert", ot_alert_no, 1);
    hi = 0; step();
    chk("R6 status holds above hysteresis", ot_status, 1);
    hi = 1; step();
    chk("R5 fresh rise reasserts", ot_alert_no, 0);
    hi = 0; lo = 1; step();
    chk("R6 status clears below hysteresis", ot_status, 0);
    chk("R5 alert not cleared by temperature", ot_alert_no, 0);
    lo = 0; cs_pulse();
  endtask

  task automatic t_inactive();
    wet_en = 0; hi = 1; step();
    chk("R7 wetting off alert idle", ot_alert_no, 1);
    chk("R7 wetting off status idle", ot_status, 0);
    hi = 0; wet_en = 1; all_open = 1; step();
    hi = 1; step();
    chk("R7 all open alert idle", ot_alert_no, 1);
    chk("R7 all open status idle", ot_status, 0);
    all_open = 0; step();
    chk("R7 resume with flag high is rise", ot_alert_no, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_irq_basic();
    t_masked();
    t_same_cycle();
    t_direct();
    t_therm();
    t_inactive();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule